// File: doc/BRIEF.md
# Eight-Channel DMA Register Front End

This block is the software-visible control and status layer that sits in front of a two-direction DMA engine with eight channels per direction ("write" = direction 0, "read" = direction 1). A 32-bit register bus with single-cycle writes and combinational reads lets software turn each direction on, program every channel's control, size and address words, and start a channel by writing its number to that direction's doorbell. The data mover itself is not part of the block. It appears only as per-channel start pulses going out and per-channel done and abort pulses coming back.

Completions are recorded in a per-direction status word. Done flags sit in bits [7:0] and abort flags in bits [23:16]. Software clears these flags by writing ones. A per-direction mask, where 1 means suppressed, gates the status bits onto a single interrupt line. The channel words can be reached in two ways, chosen by the `UNROLLED` build parameter. In the first, a selector register picks a direction and channel, and a small shared viewport then addresses that channel. In the second, every channel has its own computed address window. Software tells the two layouts apart by reading a layout identifier register.

Top module: `chan_dma_regfile`

## Requirements
- R1: After reset the following hold: both enables read 0, both status words read 0, both masks read 0xFFFFFFFF, no channel is busy, no start pulse is driven and `irq` is 0.
- R2: The write direction uses registers at 0x000 and the read direction uses registers at 0x020. At offset +0x00 of each is the enable, with bit 0 significant. A doorbell written while that direction's enable is 0 changes no busy flag and produces no start pulse.
- R3: A direction also has a doorbell at +0x04. Writing a value c < 8 there while the direction is enabled and channel c is idle sets busy bit c. It also drives start bit c high for exactly one cycle, and both happen in the cycle after the write.
- R4: A doorbell value of 8 or above, or one that names a channel that is already busy, is ignored.
- R5: A done pulse on a busy channel clears its busy bit. It sets status bit c (at +0x08) only if bit 3 of that channel's control word 1 is set. Done or abort pulses on an idle channel change nothing.
- R6: An abort pulse on a busy channel clears its busy bit and sets status bit 16+c, whatever control word 1 holds.
- R7: Writing to a direction's clear register (+0x10) clears each status bit whose written bit is 1 and leaves the others unchanged.
- R8: A direction's mask is at +0x0C. `irq` is 1 exactly when some status bit of either direction has its mask bit at 0.
- R9: Viewport layout: the selector at 0x044 holds the direction in bit 31 and the channel in bits [2:0], and reads back as written. The channel words at 0x080, 0x084, 0x088, 0x08C, 0x090, 0x094 and 0x098 (control 1, control 2, size, source low/high, destination low/high) then store and return that channel's values.
- R10: Unrolled layout: channel c of direction d has its seven words at 0x1000 + 0x200*(c+1) + 0x100*d + 4*k, for k = 0..6 in the same order. A viewport build leaves this window unmapped, so it reads 0 and writes do nothing.
- R11: The layout identifier at 0x040 reads 0xFFFFFFFF in the unrolled build and 0 in the viewport build. In the unrolled build the selector and viewport addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe, sampled on the rising edge |
| busAddr | input | ADDR_W | Byte address for reads and writes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| wrDone | input | NUM_CH | Per-channel completion pulses, write direction |
| wrAbort | input | NUM_CH | Per-channel error pulses, write direction |
| rdDone | input | NUM_CH | Per-channel completion pulses, read direction |
| rdAbort | input | NUM_CH | Per-channel error pulses, read direction |
| wrBusy | output | NUM_CH | Per-channel busy flags, write direction |
| rdBusy | output | NUM_CH | Per-channel busy flags, read direction |
| wrStart | output | NUM_CH | One-cycle start pulses to the engine, write direction |
| rdStart | output | NUM_CH | One-cycle start pulses to the engine, read direction |
| irq | output | 1 | OR of all unmasked status bits |

## Verification
The testbench builds one instance of each layout and drives both from the same bus. Each instance therefore sees the other layout's addresses, and a read from those addresses must return 0. Every direction, channel and word is written with a value that encodes its coordinates, then read back. A value landing in the wrong slot, or a swapped direction bit, shows up as a mismatch. The bench then runs the full lifecycle on all sixteen channels, alternating the interrupt-enable bit and mixing done and abort completions. This separates the gating of done flags from the ungated abort flags and confirms that each flag lands in its own bit. Finally, targeted sequences cover out-of-range, busy-channel and disabled-direction doorbells, partial write-one-to-clear patterns and single-bit mask openings.

// File: rtl/chan_dma_pkg.sv
package chan_dma_pkg;

  // Word fields per channel: control 1, control 2, size, src lo/hi, dst lo/hi
  localparam int FIELDS = 7;

  localparam logic [31:0] A_LAYOUT  = 32'h0000_0040;
  localparam logic [31:0] A_SELECT  = 32'h0000_0044;
  localparam logic [31:0] A_VP_CHAN = 32'h0000_0080;

  typedef enum logic [3:0] {
    K_NONE, K_EN, K_DB, K_STAT, K_MASK, K_CLR, K_LAYOUT, K_SELECT, K_CHAN
  } regKindT;

  typedef struct packed {
    logic    we;
    regKindT kind;
    logic    dir;
    logic [7:0] ch;
    logic [2:0] field;
  } regStrbT;

endpackage

// File: rtl/chan_dma_ctrl.sv
module chan_dma_ctrl
  import chan_dma_pkg::*;
#(
  parameter int          NUM_CH   = 8,
  parameter bit          UNROLLED = 1'b0,
  parameter int unsigned WIN_BASE = 32'h1000,
  parameter int          ADDR_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output regStrbT           strb,
  output logic [31:0]       selQ
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [31:0] addr;
  logic        chHit;
  logic        chDir;
  logic [7:0]  chIdx;
  logic [2:0]  chField;
  logic        unusedWd;

  assign addr     = 32'(busAddr);
  assign unusedWd = ^busWdata[30:CH_W];

  generate
    if (UNROLLED) begin : g_unrolled
      localparam int unsigned WIN_LO = WIN_BASE + 32'h200;
      localparam int unsigned WIN_HI = WIN_BASE + 32'h200 * (NUM_CH + 1);
      logic [31:0] rel;
      assign rel     = addr - WIN_BASE;
      assign chHit   = (addr >= WIN_LO) && (addr < WIN_HI) &&
                       (rel[7:0] <= 8'h18) && (rel[1:0] == 2'b00);
      assign chDir   = rel[8];
      assign chIdx   = 8'((rel >> 9) - 32'd1);
      assign chField = rel[4:2];
    end else begin : g_viewport
      assign chHit   = (addr >= A_VP_CHAN) && (addr <= A_VP_CHAN + 32'h18) &&
                       (addr[1:0] == 2'b00);
      assign chDir   = selQ[31];
      assign chIdx   = 8'(selQ[CH_W-1:0]);
      assign chField = addr[4:2];
    end
  endgenerate

  always_comb begin
    strb      = '0;
    strb.kind = K_NONE;
    strb.we   = busWe;
    if (addr < 32'h40 && addr[1:0] == 2'b00 && addr[4:2] <= 3'd4) begin
      strb.dir = addr[5];
      case (addr[4:2])
        3'd0:    strb.kind = K_EN;
        3'd1:    strb.kind = K_DB;
        3'd2:    strb.kind = K_STAT;
        3'd3:    strb.kind = K_MASK;
        default: strb.kind = K_CLR;
      endcase
    end else if (addr == A_LAYOUT) begin
      strb.kind = K_LAYOUT;
    end else if (addr == A_SELECT) begin
      strb.kind = K_SELECT;
    end else if (chHit) begin
      strb.kind  = K_CHAN;
      strb.dir   = chDir;
      strb.ch    = chIdx;
      strb.field = chField;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ <= '0;
    end else if (!UNROLLED && busWe && addr == A_SELECT) begin
      selQ <= {busWdata[31], {(31-CH_W){1'b0}}, busWdata[CH_W-1:0]};
    end
  end

  // R9: the selector only moves on a bus write to its address
  a_r9_select_write_only: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(selQ) |-> ($past(busWe) && $past(addr) == A_SELECT));

endmodule

// File: rtl/chan_dma_regs.sv
module chan_dma_regs
  import chan_dma_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter bit UNROLLED = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  regStrbT                strb,
  input  logic [31:0]            busWdata,
  input  logic [31:0]            selQ,
  input  logic [1:0]             dirEn,
  input  logic [1:0][31:0]       dirMask,
  input  logic [1:0][31:0]       dirStat,
  output logic [1:0][NUM_CH-1:0] lie,
  output logic [31:0]            rdata
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [31:0] chanReg [2][NUM_CH][FIELDS];
  logic        chanOk;

  assign chanOk = (strb.kind == K_CHAN) && (32'(strb.ch) < NUM_CH) &&
                  (32'(strb.field) < FIELDS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int d = 0; d < 2; d++)
        for (int c = 0; c < NUM_CH; c++)
          for (int k = 0; k < FIELDS; k++)
            chanReg[d][c][k] <= '0;
    end else if (strb.we && chanOk) begin
      chanReg[strb.dir][strb.ch[CH_W-1:0]][strb.field] <= busWdata;
    end
  end

  generate
    for (genvar d = 0; d < 2; d++) begin : g_lieDir
      for (genvar c = 0; c < NUM_CH; c++) begin : g_lieCh
        assign lie[d][c] = chanReg[d][c][0][3];
      end
    end
  endgenerate

  always_comb begin
    rdata = '0;
    case (strb.kind)
      K_EN:     rdata = {31'b0, dirEn[strb.dir]};
      K_STAT:   rdata = dirStat[strb.dir];
      K_MASK:   rdata = dirMask[strb.dir];
      K_LAYOUT: rdata = UNROLLED ? 32'hFFFF_FFFF : 32'h0;
      K_SELECT: rdata = selQ;
      K_CHAN:   if (chanOk) rdata = chanReg[strb.dir][strb.ch[CH_W-1:0]][strb.field];
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/chan_dma_dir.sv
module chan_dma_dir
  import chan_dma_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DIR    = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrbT           strb,
  input  logic [31:0]       busWdata,
  input  logic [NUM_CH-1:0] lie,
  input  logic [NUM_CH-1:0] doneIn,
  input  logic [NUM_CH-1:0] abortIn,
  output logic              enO,
  output logic [31:0]       maskO,
  output logic [31:0]       statO,
  output logic [NUM_CH-1:0] busyO,
  output logic [NUM_CH-1:0] startO
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic              enQ;
  logic [31:0]       maskQ;
  logic [NUM_CH-1:0] doneSt, abortSt, busyQ, startQ;
  logic              mine, dbOk, clrHit;
  logic [CH_W-1:0]   dbCh;

  assign mine   = strb.we && (strb.dir == 1'(DIR));
  assign dbCh   = busWdata[CH_W-1:0];
  assign dbOk   = mine && strb.kind == K_DB && enQ &&
                  busWdata < 32'(NUM_CH) && !busyQ[dbCh];
  assign clrHit = mine && strb.kind == K_CLR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ     <= 1'b0;
      maskQ   <= '1;
      doneSt  <= '0;
      abortSt <= '0;
      busyQ   <= '0;
      startQ  <= '0;
    end else begin
      if (mine && strb.kind == K_EN)   enQ   <= busWdata[0];
      if (mine && strb.kind == K_MASK) maskQ <= busWdata;
      for (int c = 0; c < NUM_CH; c++) begin
        startQ[c] <= dbOk && (dbCh == CH_W'(c));
        if (dbOk && dbCh == CH_W'(c))       busyQ[c] <= 1'b1;
        else if (doneIn[c] || abortIn[c])   busyQ[c] <= 1'b0;
        if (busyQ[c] && doneIn[c] && lie[c]) doneSt[c] <= 1'b1;
        else if (clrHit && busWdata[c])      doneSt[c] <= 1'b0;
        if (busyQ[c] && abortIn[c])          abortSt[c] <= 1'b1;
        else if (clrHit && busWdata[16+c])   abortSt[c] <= 1'b0;
      end
    end
  end

  assign enO    = enQ;
  assign maskO  = maskQ;
  assign statO  = 32'(doneSt) | (32'(abortSt) << 16);
  assign busyO  = busyQ;
  assign startO = startQ;

  // R2: a channel only turns busy if the direction was enabled
  a_r2_busy_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    ((busyQ & ~$past(busyQ)) != '0) |-> $past(enQ));

  // R3: start pulses are single and follow a doorbell write to this direction
  a_r3_start_from_doorbell: assert property (@(posedge clk) disable iff (!rstN)
    (startQ != '0) |-> ($onehot(startQ) && $past(strb.we) &&
                        $past(strb.kind) == K_DB && $past(strb.dir) == 1'(DIR)));

  // R5: a done flag only rises on a channel whose interrupt enable was set
  a_r5_done_needs_lie: assert property (@(posedge clk) disable iff (!rstN)
    ((doneSt & ~$past(doneSt)) != '0) |->
      (((doneSt & ~$past(doneSt)) & ~$past(lie)) == '0));

  // R6: busy only drops after a completion or error pulse
  a_r6_busy_drop_cause: assert property (@(posedge clk) disable iff (!rstN)
    (($past(busyQ) & ~busyQ) != '0) |-> (($past(doneIn | abortIn) & $past(busyQ) & ~busyQ) != '0));

endmodule

// File: rtl/chan_dma_regfile.sv
module chan_dma_regfile
  import chan_dma_pkg::*;
#(
  parameter int          NUM_CH   = 8,
  parameter bit          UNROLLED = 1'b0,
  parameter int unsigned WIN_BASE = 32'h1000,
  parameter int          ADDR_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic [NUM_CH-1:0] wrDone,
  input  logic [NUM_CH-1:0] wrAbort,
  input  logic [NUM_CH-1:0] rdDone,
  input  logic [NUM_CH-1:0] rdAbort,
  output logic [NUM_CH-1:0] wrBusy,
  output logic [NUM_CH-1:0] rdBusy,
  output logic [NUM_CH-1:0] wrStart,
  output logic [NUM_CH-1:0] rdStart,
  output logic              irq
);
  regStrbT                strb;
  logic [31:0]            selQ;
  logic [1:0]             enV;
  logic [1:0][31:0]       maskV, statV;
  logic [1:0][NUM_CH-1:0] doneV, abortV, busyV, startV, lieV;

  assign doneV  = {rdDone, wrDone};
  assign abortV = {rdAbort, wrAbort};

  chan_dma_ctrl #(.NUM_CH(NUM_CH), .UNROLLED(UNROLLED), .WIN_BASE(WIN_BASE),
                  .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .strb(strb), .selQ(selQ));

  chan_dma_regs #(.NUM_CH(NUM_CH), .UNROLLED(UNROLLED)) u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .selQ(selQ),
    .dirEn(enV), .dirMask(maskV), .dirStat(statV), .lie(lieV), .rdata(busRdata));

  generate
    for (genvar d = 0; d < 2; d++) begin : g_dir
      chan_dma_dir #(.NUM_CH(NUM_CH), .DIR(d)) u_dir (
        .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
        .lie(lieV[d]), .doneIn(doneV[d]), .abortIn(abortV[d]),
        .enO(enV[d]), .maskO(maskV[d]), .statO(statV[d]),
        .busyO(busyV[d]), .startO(startV[d]));
    end
  endgenerate

  assign wrBusy  = busyV[0];
  assign rdBusy  = busyV[1];
  assign wrStart = startV[0];
  assign rdStart = startV[1];
  assign irq     = |((statV[0] & ~maskV[0]) | (statV[1] & ~maskV[1]));

  // R11: the layout identifier tells software which channel layout is built
  a_r11_layout_id: assert property (@(posedge clk) disable iff (!rstN)
    (32'(busAddr) == A_LAYOUT) |-> (busRdata == (UNROLLED ? 32'hFFFF_FFFF : 32'h0)));

endmodule

// File: tb/chan_dma_regfile_test.sv
module chan_dma_regfile_test;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [15:0] busAddr = 16'hFFF0;
  logic [31:0] busWdata = '0;
  logic [N-1:0] wrDone = '0, wrAbort = '0, rdDone = '0, rdAbort = '0;
  logic [31:0] rdV, rdU;
  logic [N-1:0] wbV, rbV, wsV, rsV, wbU, rbU, wsU, rsU;
  logic irqV, irqU;
  int nRun = 0, nFail = 0;
  logic [31:0] expStat [2];
  logic [31:0] expMask [2];

  always #2 clk = ~clk;

  chan_dma_regfile #(.NUM_CH(N), .UNROLLED(1'b0)) uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(rdV), .wrDone(wrDone), .wrAbort(wrAbort), .rdDone(rdDone),
    .rdAbort(rdAbort), .wrBusy(wbV), .rdBusy(rbV), .wrStart(wsV), .rdStart(rsV),
    .irq(irqV));

  chan_dma_regfile #(.NUM_CH(N), .UNROLLED(1'b1)) uutU (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(rdU), .wrDone(wrDone), .wrAbort(wrAbort), .rdDone(rdDone),
    .rdAbort(rdAbort), .wrBusy(wbU), .rdBusy(rbU), .wrStart(wsU), .rdStart(rsU),
    .irq(irqU));

  function automatic logic [15:0] winAddr(int d, int c, int k);
    return 16'(32'h1000 + 32'h200 * (c + 1) + 32'h100 * d + 4 * k);
  endfunction

  function automatic logic [31:0] pat(int d, int c, int k);
    return 32'hA500_0000 | (d << 20) | (c << 12) | (k << 4) | k;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] v);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = v;
    @(negedge clk);
    busWe = 1'b0; busAddr = 16'hFFF0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v0, output logic [31:0] v1);
    @(negedge clk);
    busAddr = a;
    #1;
    v0 = rdV; v1 = rdU;
  endtask

  task automatic pulse(input int d, input int c, input bit ab);
    @(negedge clk);
    if (d == 0) begin
      if (ab) wrAbort[c] = 1'b1; else wrDone[c] = 1'b1;
    end else begin
      if (ab) rdAbort[c] = 1'b1; else rdDone[c] = 1'b1;
    end
    @(negedge clk);
    wrDone = '0; wrAbort = '0; rdDone = '0; rdAbort = '0;
  endtask

  task automatic chkBusyStart(input string tag, input int d,
                              input logic [31:0] eb, input logic [31:0] es);
    chk({tag, " busy"},    32'(d ? rbV : wbV), eb);
    chk({tag, " busyU"},   32'(d ? rbU : wbU), eb);
    chk({tag, " start"},   32'(d ? rsV : wsV), es);
    chk({tag, " startU"},  32'(d ? rsU : wsU), es);
  endtask

  function automatic logic expIrq();
    return |((expStat[0] & ~expMask[0]) | (expStat[1] & ~expMask[1]));
  endfunction

  task automatic chkStat(input string tag);
    logic [31:0] a, b;
    for (int d = 0; d < 2; d++) begin
      rd(16'(32'h08 + 32'h20 * d), a, b);
      chk({tag, " stat"},  a, expStat[d]);
      chk({tag, " statU"}, b, expStat[d]);
    end
    chk({tag, " irq R8"},  32'(irqV), 32'(expIrq()));
    chk({tag, " irqU R8"}, 32'(irqU), 32'(expIrq()));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [31:0] a, b;
    expStat[0] = '0; expStat[1] = '0;
    expMask[0] = '1; expMask[1] = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int d = 0; d < 2; d++) begin
      rd(16'(32'h20 * d), a, b);          chk("R1 enable", a, 0);   chk("R1 enableU", b, 0);
      rd(16'(32'h20 * d + 8), a, b);      chk("R1 status", a, 0);   chk("R1 statusU", b, 0);
      rd(16'(32'h20 * d + 12), a, b);     chk("R1 mask", a, '1);    chk("R1 maskU", b, '1);
      chkBusyStart("R1", d, 0, 0);
    end
    chk("R1 irq", 32'(irqV), 0); chk("R1 irqU", 32'(irqU), 0);

    // R11: layout identifier
    rd(16'h0040, a, b);
    chk("R11 layout viewport", a, 32'h0); chk("R11 layout unrolled", b, 32'hFFFF_FFFF);

    // R9 / R10 / R11: fill every channel word through both layouts
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < N; c++) begin
        wr(16'h0044, (d << 31) | c);
        for (int k = 0; k < 7; k++) wr(16'(32'h80 + 4 * k), pat(d, c, k));
      end
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < N; c++)
        for (int k = 0; k < 7; k++) wr(winAddr(d, c, k), ~pat(d, c, k));
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < N; c++) begin
        wr(16'h0044, (d << 31) | c);
        rd(16'h0044, a, b);
        chk("R9 selector readback", a, (d << 31) | c);
        chk("R11 selector inert unrolled", b, 0);
        for (int k = 0; k < 7; k++) begin
          rd(16'(32'h80 + 4 * k), a, b);
          chk("R9 viewport word", a, pat(d, c, k));
          chk("R11 viewport inert unrolled", b, 0);
          rd(winAddr(d, c, k), a, b);
          chk("R10 window word", b, ~pat(d, c, k));
          chk("R10 window unmapped viewport", a, 0);
        end
      end
    rd(16'(32'h1000 + 32'h200 * (N + 1)), a, b);
    chk("R10 past window end", b, 0);

    // R2: doorbell while disabled
    wr(16'h0004, 2);
    chkBusyStart("R2 disabled doorbell", 0, 0, 0);
    wr(16'h0000, 1); wr(16'h0020, 1);
    rd(16'h0000, a, b); chk("R2 enable wr", a, 1); chk("R2 enable wrU", b, 1);
    rd(16'h0020, a, b); chk("R2 enable rd", a, 1); chk("R2 enable rdU", b, 1);

    // R3 / R5 / R6 / R8: lifecycle on every channel
    wr(16'h000C, 0); wr(16'h002C, 0);
    expMask[0] = 0; expMask[1] = 0;
    for (int d = 0; d < 2; d++)
      for (int c = 0; c < N; c++) begin
        bit lieOn, ab;
        lieOn = (c % 2 == 0);
        ab    = (c % 3 == 2);
        wr(16'h0044, (d << 31) | c);
        wr(16'h0080, lieOn ? 32'h8 : 32'h0);
        wr(winAddr(d, c, 0), lieOn ? 32'h8 : 32'h0);
        wr(16'(32'h20 * d + 4), c);
        chkBusyStart("R3 doorbell accepted", d, 1 << c, 1 << c);
        @(negedge clk);
        chkBusyStart("R3 start one cycle", d, 1 << c, 0);
        pulse(d, c, ab);
        chkBusyStart(ab ? "R6 abort clears busy" : "R5 done clears busy", d, 0, 0);
        if (ab) expStat[d] = expStat[d] | (32'h1 << (16 + c));
        else if (lieOn) expStat[d] = expStat[d] | (32'h1 << c);
        chkStat(ab ? "R6" : "R5");
      end

    // R7: write-one-to-clear
    wr(16'h0010, 32'h0004_0011);
    expStat[0] = expStat[0] & ~32'h0004_0011;
    chkStat("R7 partial clear");
    wr(16'h0030, 32'hFFFF_FFFF);
    expStat[1] = 0;
    chkStat("R7 full clear");

    // R8: mask gating
    wr(16'h000C, '1); wr(16'h002C, '1);
    expMask[0] = '1; expMask[1] = '1;
    chkStat("R8 all masked");
    wr(16'h000C, ~32'h40);
    expMask[0] = ~32'h40;
    chkStat("R8 open set bit");
    wr(16'h000C, ~32'h2);
    expMask[0] = ~32'h2;
    chkStat("R8 open clear bit");
    rd(16'h000C, a, b); chk("R8 mask readback", a, ~32'h2);

    // R4: out-of-range and busy-channel doorbells
    wr(16'h0004, 8);
    chkBusyStart("R4 channel 8", 0, 0, 0);
    wr(16'h0004, 32'h103);
    chkBusyStart("R4 channel 0x103", 0, 0, 0);
    wr(16'h0004, 3);
    chkBusyStart("R4 first accepted", 0, 1 << 3, 1 << 3);
    wr(16'h0004, 3);
    chkBusyStart("R4 busy channel ignored", 0, 1 << 3, 0);
    pulse(0, 3, 1'b0);
    chkBusyStart("R5 done no lie", 0, 0, 0);
    chkStat("R5 done no lie status");

    // R5: pulses on idle channels change nothing
    pulse(0, 4, 1'b0);
    pulse(1, 1, 1'b1);
    chkBusyStart("R5 idle done", 0, 0, 0);
    chkStat("R5 idle pulses");

    // R2: disabling again blocks doorbells
    wr(16'h0020, 0);
    rd(16'h0020, a, b); chk("R2 disable readback", a, 0);
    wr(16'h0024, 1);
    chkBusyStart("R2 disabled again", 1, 0, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule